// File: doc/BRIEF.md
# Quad Serial DAC Update Sequencer

This block sits on the host side of a four-channel serial digital-to-analog converter. It takes commands through a valid/ready handshake and turns each one into the converter's pin sequence, driven from the system clock. A write command carries a 2-bit channel number and a 12-bit code. For a write the block shifts a 16-bit word out on a serial select, clock and data trio, then gives an active-low per-register stage strobe. It can also give an active-low commit strobe that moves all four staged codes to the outputs at once. An update command gives the commit strobe alone. A clear command first sets a level-select output, then pulses an active-low clear line.

Each minimum interval on the converter pins is a nanosecond parameter. The block turns it into a count of system clocks by rounding up, with a floor of one. The defaults assume a 4 ns clock. While the block is idle, every strobe and the serial clock rest high, so a stray shift edge cannot occur.

Top module: `qdac_seq`

## Requirements
- R1: A write (cmd_kind 0) sends exactly one 16-bit frame, most significant bit first: cmd_chan (2 bits), then two zero filler bits, then cmd_code bit 11 down to bit 0. One bit is taken on each rising ser_clk edge while ser_sel_n is low.
- R2: Each ser_clk low phase lasts at least 50 ns and each high phase at least 30 ns. ser_dat changes only while ser_clk is low. It is stable at least 25 ns before each rising edge and for at least 20 ns after it.
- R3: ser_sel_n falls at least 55 ns before the first rising ser_clk edge of a frame. It rises only while ser_clk is high, at least 15 ns after the last rising edge. ser_clk rests high outside frames.
- R4: stage_n is high for at least 40 ns before the first rising ser_clk edge of a frame. It falls at least 15 ns after the last rising edge, and only while ser_sel_n and ser_clk are both high. It stays low for at least 45 ns and pulses exactly once per write.
- R5: A write with cmd_commit set is followed by one commit_n low pulse after stage_n returns high. A write with cmd_commit clear produces no commit_n pulse.
- R6: An update (cmd_kind 1) gives one commit_n low pulse of at least 45 ns and sends no frame.
- R7: A clear (cmd_kind 2) drives clr_mid to cmd_mid (1 selects mid-scale, 0 zero-scale). clr_mid is stable at least 25 ns before clr_n falls and while clr_n is low. clr_n stays low at least 70 ns, and clr_mid keeps its value afterwards.
- R8: cmd_ready is high only when the block is idle, with ser_sel_n, stage_n, commit_n and clr_n all high. It goes low from acceptance until at least 20 ns after the last strobe of the command has returned high.
- R9: cmd_kind 3 is accepted and discarded. cmd_ready stays high and no pin moves.
- R10: During and after reset, ser_sel_n, ser_clk, stage_n, commit_n and clr_n are high, clr_mid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_kind | input | 2 | 0 write, 1 update, 2 clear, 3 reserved |
| cmd_chan | input | CHAN_W | Target channel for a write |
| cmd_code | input | CODE_W | Code for a write |
| cmd_commit | input | 1 | Commit all outputs after this write |
| cmd_mid | input | 1 | Clear level: 1 mid-scale, 0 zero-scale |
| ser_sel_n | output | 1 | Serial select, active low |
| ser_clk | output | 1 | Serial shift clock, data taken on rising edge |
| ser_dat | output | 1 | Serial data |
| stage_n | output | 1 | Per-register stage strobe, active low |
| commit_n | output | 1 | Global output commit strobe, active low |
| clr_n | output | 1 | Clear strobe, active low |
| clr_mid | output | 1 | Clear level select |

## Verification
Two pairs of events share a clock edge. In the first, the stage strobe ends in the same edge where the commit strobe of a flagged write begins. In the second, the recovery interval ends in the same edge where a waiting command is accepted. The bench provokes the second by holding cmd_valid high through back-to-back writes and updates, so acceptance lands in the very cycle cmd_ready returns. The scoreboard then judges that commit_n follows stage_n in order, and that the next frame still has its full select and stage setup times. Recovery is measured as a count of quiet cycles before each rise of cmd_ready.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        K_WRITE  = 2'd0,
        K_UPDATE = 2'd1,
        K_CLEAR  = 2'd2,
        K_RSVD   = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FRAME,
        S_STAGE,
        S_COMMIT,
        S_LEVEL,
        S_CLEAR,
        S_RECOV
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LO,
        PH_HI,
        PH_END
    } frm_phase_e;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Counter width able to hold 0 .. n-1.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/qdac_strobe.sv
module qdac_strobe
    import qdac_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic pulse_no,
    output logic last_o
);
    localparam int CW = cnt_w(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } stb_st_t;

    stb_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (go_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_no = ~s_q.busy;
    assign last_o   = s_q.busy && (s_q.cnt == LAST);

    // R8: the sequencer never restarts a strobe that is still low
    a_r8_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> pulse_no);

endmodule

// File: rtl/qdac_frame.sv
module qdac_frame
    import qdac_pkg::*;
#(
    parameter int FW      = 16,
    parameter int T_FIRST = 14,
    parameter int T_LO    = 13,
    parameter int T_HI    = 8,
    parameter int T_END   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [FW-1:0] word_i,
    output logic          sel_no,
    output logic          sclk_o,
    output logic          sdat_o,
    output logic          last_o
);
    localparam int TMAX = imax(imax(T_FIRST, T_LO), imax(T_HI, T_END));
    localparam int CW   = cnt_w(TMAX);
    localparam int BW   = cnt_w(FW);
    localparam logic [CW-1:0] FIRST_LAST = CW'(T_FIRST - 1);
    localparam logic [CW-1:0] LO_LAST    = CW'(T_LO - 1);
    localparam logic [CW-1:0] HI_LAST    = CW'(T_HI - 1);
    localparam logic [CW-1:0] END_LAST   = CW'(T_END - 1);
    localparam logic [BW-1:0] BIT_LAST   = BW'(FW - 1);

    typedef struct packed {
        frm_phase_e    phase;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [FW-1:0] shf;
        logic          sel_n;
        logic          sclk;
        logic          sdat;
    } frm_st_t;

    frm_st_t s_d, s_q;
    logic [CW-1:0] lo_last;

    assign lo_last = (s_q.bitn == '0) ? FIRST_LAST : LO_LAST;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (go_i) begin
                    s_d.phase = PH_LO;
                    s_d.cnt   = '0;
                    s_d.bitn  = '0;
                    s_d.sel_n = 1'b0;
                    s_d.sclk  = 1'b0;
                    s_d.sdat  = word_i[FW-1];
                    s_d.shf   = {word_i[FW-2:0], 1'b0};
                end
            end
            PH_LO: begin
                if (s_q.cnt == lo_last) begin
                    s_d.phase = PH_HI;
                    s_d.cnt   = '0;
                    s_d.sclk  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HI: begin
                if (s_q.cnt == HI_LAST) begin
                    s_d.cnt = '0;
                    if (s_q.bitn == BIT_LAST) begin
                        s_d.phase = PH_END;
                    end else begin
                        s_d.phase = PH_LO;
                        s_d.sclk  = 1'b0;
                        s_d.sdat  = s_q.shf[FW-1];
                        s_d.shf   = {s_q.shf[FW-2:0], 1'b0};
                        s_d.bitn  = s_q.bitn + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_END: begin
                if (s_q.cnt == END_LAST) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                    s_d.sel_n = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, bitn: '0, shf: '0,
                     sel_n: 1'b1, sclk: 1'b1, sdat: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_no = s_q.sel_n;
    assign sclk_o = s_q.sclk;
    assign sdat_o = s_q.sdat;
    assign last_o = (s_q.phase == PH_END) && (s_q.cnt == END_LAST);

    // R3: select may only rise while the shift clock is high
    a_r3_sel_rise_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_no) |-> sclk_o);

    // R2: data holds still for as long as the shift clock stays high
    a_r2_dat_still_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));

    // R8: a new frame only starts from the resting state
    a_r8_frame_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (sel_no && sclk_o));

endmodule

// File: rtl/qdac_seq.sv
module qdac_seq
    import qdac_pkg::*;
#(
    parameter int CHAN_W        = 2,
    parameter int CODE_W        = 12,
    parameter int PAD_W         = 2,
    parameter int CLK_PERIOD_NS = 4,
    parameter int DAT_SU_NS     = 25,
    parameter int DAT_HO_NS     = 20,
    parameter int SCK_HI_NS     = 30,
    parameter int SCK_LO_NS     = 50,
    parameter int SEL_SU_NS     = 55,
    parameter int SEL_HO_NS     = 15,
    parameter int STG_SU_NS     = 40,
    parameter int STG_DLY_NS    = 15,
    parameter int STG_W_NS      = 45,
    parameter int CMT_W_NS      = 45,
    parameter int LVL_SU_NS     = 25,
    parameter int CLR_W_NS      = 70,
    parameter int RECOV_NS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_kind,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_commit,
    input  logic              cmd_mid,
    output logic              ser_sel_n,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              stage_n,
    output logic              commit_n,
    output logic              clr_n,
    output logic              clr_mid
);
    localparam int FW      = CHAN_W + PAD_W + CODE_W;
    localparam int C_DSU   = ns_to_cyc(DAT_SU_NS,  CLK_PERIOD_NS);
    localparam int C_DHO   = ns_to_cyc(DAT_HO_NS,  CLK_PERIOD_NS);
    localparam int C_SKH   = ns_to_cyc(SCK_HI_NS,  CLK_PERIOD_NS);
    localparam int C_SKL   = ns_to_cyc(SCK_LO_NS,  CLK_PERIOD_NS);
    localparam int C_SSU   = ns_to_cyc(SEL_SU_NS,  CLK_PERIOD_NS);
    localparam int C_SHO   = ns_to_cyc(SEL_HO_NS,  CLK_PERIOD_NS);
    localparam int C_GSU   = ns_to_cyc(STG_SU_NS,  CLK_PERIOD_NS);
    localparam int C_GDL   = ns_to_cyc(STG_DLY_NS, CLK_PERIOD_NS);
    localparam int C_GW    = ns_to_cyc(STG_W_NS,   CLK_PERIOD_NS);
    localparam int C_CW    = ns_to_cyc(CMT_W_NS,   CLK_PERIOD_NS);
    localparam int C_LSU   = ns_to_cyc(LVL_SU_NS,  CLK_PERIOD_NS);
    localparam int C_RW    = ns_to_cyc(CLR_W_NS,   CLK_PERIOD_NS);
    localparam int C_REC   = ns_to_cyc(RECOV_NS,   CLK_PERIOD_NS);

    localparam int T_LO    = imax(C_SKL, C_DSU);
    localparam int T_HI    = imax(C_SKH, C_DHO);
    localparam int T_FIRST = imax(T_LO, imax(C_SSU, C_GSU));
    localparam int T_END   = imax(C_SHO, C_GDL);

    localparam int N_STB   = 3;
    localparam int STB_STG = 0;
    localparam int STB_CMT = 1;
    localparam int STB_CLR = 2;
    localparam int STB_W [N_STB] = '{C_GW, C_CW, C_RW};

    localparam int TW = cnt_w(imax(C_LSU, C_REC));
    localparam logic [TW-1:0] LVL_LAST = TW'(C_LSU - 1);
    localparam logic [TW-1:0] REC_LAST = TW'(C_REC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [TW-1:0] tmr;
        logic          cmt;
        logic          mid;
    } seq_st_t;

    seq_st_t          s_d, s_q;
    logic             frame_go;
    logic             frame_last;
    logic [FW-1:0]    frame_word;
    logic [N_STB-1:0] stb_go;
    logic [N_STB-1:0] stb_n;
    logic [N_STB-1:0] stb_last;

    assign frame_word = {cmd_chan, {PAD_W{1'b0}}, cmd_code};
    assign cmd_ready  = (s_q.state == S_IDLE);

    always_comb begin
        s_d      = s_q;
        frame_go = 1'b0;
        stb_go   = '0;
        unique case (s_q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_kind_e'(cmd_kind))
                        K_WRITE: begin
                            frame_go  = 1'b1;
                            s_d.cmt   = cmd_commit;
                            s_d.state = S_FRAME;
                        end
                        K_UPDATE: begin
                            stb_go[STB_CMT] = 1'b1;
                            s_d.state       = S_COMMIT;
                        end
                        K_CLEAR: begin
                            s_d.mid   = cmd_mid;
                            s_d.tmr   = '0;
                            s_d.state = S_LEVEL;
                        end
                        default: ;
                    endcase
                end
            end
            S_FRAME: begin
                if (frame_last) begin
                    stb_go[STB_STG] = 1'b1;
                    s_d.state       = S_STAGE;
                end
            end
            S_STAGE: begin
                if (stb_last[STB_STG]) begin
                    if (s_q.cmt) begin
                        stb_go[STB_CMT] = 1'b1;
                        s_d.state       = S_COMMIT;
                    end else begin
                        s_d.tmr   = '0;
                        s_d.state = S_RECOV;
                    end
                end
            end
            S_COMMIT: begin
                if (stb_last[STB_CMT]) begin
                    s_d.tmr   = '0;
                    s_d.state = S_RECOV;
                end
            end
            S_LEVEL: begin
                if (s_q.tmr == LVL_LAST) begin
                    stb_go[STB_CLR] = 1'b1;
                    s_d.state       = S_CLEAR;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            S_CLEAR: begin
                if (stb_last[STB_CLR]) begin
                    s_d.tmr   = '0;
                    s_d.state = S_RECOV;
                end
            end
            S_RECOV: begin
                if (s_q.tmr == REC_LAST) begin
                    s_d.state = S_IDLE;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, tmr: '0, cmt: 1'b0, mid: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    qdac_frame #(
        .FW      (FW),
        .T_FIRST (T_FIRST),
        .T_LO    (T_LO),
        .T_HI    (T_HI),
        .T_END   (T_END)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (frame_go),
        .word_i (frame_word),
        .sel_no (ser_sel_n),
        .sclk_o (ser_clk),
        .sdat_o (ser_dat),
        .last_o (frame_last)
    );

    for (genvar g = 0; g < N_STB; g++) begin : g_stb
        qdac_strobe #(
            .WIDTH (STB_W[g])
        ) u_stb (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_i     (stb_go[g]),
            .pulse_no (stb_n[g]),
            .last_o   (stb_last[g])
        );
    end

    assign stage_n  = stb_n[STB_STG];
    assign commit_n = stb_n[STB_CMT];
    assign clr_n    = stb_n[STB_CLR];
    assign clr_mid  = s_q.mid;

    // R4: the stage strobe is low only after the frame has closed
    a_r4_stage_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_n |-> (ser_sel_n && ser_clk));

    // R7: the level select never moves while clear is low
    a_r7_level_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !$past(clr_n)) |-> $stable(clr_mid));

    // R8: ready implies every pin is resting
    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (ser_sel_n && stage_n && commit_n && clr_n));

    // R5: at most one strobe is low at a time
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~stb_n) <= 1);

endmodule

// File: tb/qdac_seq_tb.sv
module qdac_seq_tb;
    localparam int PER = 4;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int M_DSU = cyc(25);
    localparam int M_DHO = cyc(20);
    localparam int M_SKH = cyc(30);
    localparam int M_SKL = cyc(50);
    localparam int M_SSU = cyc(55);
    localparam int M_SHO = cyc(15);
    localparam int M_GSU = cyc(40);
    localparam int M_GDL = cyc(15);
    localparam int M_GW  = cyc(45);
    localparam int M_CW  = cyc(45);
    localparam int M_LSU = cyc(25);
    localparam int M_RW  = cyc(70);
    localparam int M_REC = cyc(20);

    localparam logic [1:0] EV_STG = 2'd0;
    localparam logic [1:0] EV_CMT = 2'd1;
    localparam logic [1:0] EV_CLR = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_kind = 2'd0;
    logic [1:0]  cmd_chan = 2'd0;
    logic [11:0] cmd_code = 12'd0;
    logic        cmd_commit = 1'b0;
    logic        cmd_mid = 1'b0;
    logic        ser_sel_n, ser_clk, ser_dat, stage_n, commit_n, clr_n, clr_mid;

    int checks = 0;
    int errors = 0;
    logic [17:0] exp_q[$];

    // monitor state
    logic p_clk, p_sel, p_dat, p_stg, p_cmt, p_clr, p_mid, p_rdy;
    int lo_cnt, hi_cnt, dat_age, since_rise, sel_age, stg_hi_age;
    int stg_lo, cmt_lo, clr_lo, mid_age, quiet, bits;
    int n_frames, n_commits;
    logic [15:0] word;

    always #(PER / 2) clk = ~clk;

    qdac_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_kind   (cmd_kind),
        .cmd_chan   (cmd_chan),
        .cmd_code   (cmd_code),
        .cmd_commit (cmd_commit),
        .cmd_mid    (cmd_mid),
        .ser_sel_n  (ser_sel_n),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .stage_n    (stage_n),
        .commit_n   (commit_n),
        .clr_n      (clr_n),
        .clr_mid    (clr_mid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pop_chk(input logic [1:0] kind, input logic [15:0] val, input string req);
        logic [17:0] e;
        if (exp_q.size() == 0) begin
            chk(1'b0, {req, " unexpected strobe"}, kind, 99);
        end else begin
            e = exp_q.pop_front();
            chk(e[17:16] == kind, {req, " strobe order"}, kind, e[17:16]);
            chk(e[15:0] == val, {req, " strobe payload"}, val, e[15:0]);
        end
    endtask

    // scoreboard monitor, samples once per cycle away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            p_clk = 1; p_sel = 1; p_dat = 0; p_stg = 1; p_cmt = 1; p_clr = 1;
            p_mid = 0; p_rdy = 1;
            lo_cnt = 0; hi_cnt = 1000; dat_age = 1000; since_rise = 1000;
            sel_age = 0; stg_hi_age = 1000; stg_lo = 0; cmt_lo = 0; clr_lo = 0;
            mid_age = 1000; quiet = 1000; bits = 0; word = '0;
            n_frames = 0; n_commits = 0;
        end else begin
            since_rise++;
            if (ser_sel_n) sel_age = 0; else sel_age++;
            if (stage_n) stg_hi_age++; else stg_hi_age = 0;
            if (!ser_sel_n && p_sel) begin
                bits = 0;
                n_frames++;
            end

            // R2 data timing
            if (ser_dat !== p_dat) begin
                chk(!ser_clk, "R2 data moved while clock high", ser_clk, 0);
                chk(since_rise >= M_DHO, "R2 data hold", since_rise, M_DHO);
                dat_age = 1;
            end else begin
                dat_age++;
            end

            // R2/R3 clock phases and bit capture (R1)
            if (ser_clk && !p_clk) begin
                chk(lo_cnt >= M_SKL, "R2 clock low", lo_cnt, M_SKL);
                chk(dat_age - 1 >= M_DSU, "R2 data setup", dat_age - 1, M_DSU);
                chk(!ser_sel_n, "R3 select low at rise", ser_sel_n, 0);
                if (bits == 0) begin
                    chk(sel_age - 1 >= M_SSU, "R3 select setup", sel_age - 1, M_SSU);
                    chk(stg_hi_age - 1 >= M_GSU, "R4 stage setup", stg_hi_age - 1, M_GSU);
                end
                word = {word[14:0], ser_dat};
                bits++;
                since_rise = 0;
                hi_cnt = 1;
            end else if (!ser_clk && p_clk) begin
                chk(hi_cnt >= M_SKH, "R2 clock high", hi_cnt, M_SKH);
                lo_cnt = 1;
            end else if (ser_clk) begin
                hi_cnt++;
            end else begin
                lo_cnt++;
            end

            // R3 select release
            if (ser_sel_n && !p_sel) begin
                chk(ser_clk && p_clk, "R3 select rose with clock low", ser_clk, 1);
                chk(since_rise >= M_SHO, "R3 select hold", since_rise, M_SHO);
            end

            // R4 stage strobe
            if (!stage_n && p_stg) begin
                pop_chk(EV_STG, word, "R4");
                chk(bits == 16, "R1 bit count", bits, 16);
                chk(ser_sel_n && ser_clk, "R4 stage during frame", {ser_sel_n, ser_clk}, 3);
                chk(since_rise >= M_GDL, "R4 stage delay", since_rise, M_GDL);
                stg_lo = 1;
            end else if (!stage_n) begin
                stg_lo++;
            end else if (stage_n && !p_stg) begin
                chk(stg_lo >= M_GW, "R4 stage width", stg_lo, M_GW);
            end

            // R5/R6 commit strobe
            if (!commit_n && p_cmt) begin
                pop_chk(EV_CMT, 16'd0, "R5/R6");
                n_commits++;
                cmt_lo = 1;
            end else if (!commit_n) begin
                cmt_lo++;
            end else if (commit_n && !p_cmt) begin
                chk(cmt_lo >= M_CW, "R6 commit width", cmt_lo, M_CW);
            end

            // R7 clear strobe and level
            if (clr_mid !== p_mid) mid_age = 1; else mid_age++;
            if (!clr_n && p_clr) begin
                pop_chk(EV_CLR, {15'd0, clr_mid}, "R7");
                chk(mid_age - 1 >= M_LSU, "R7 level setup", mid_age - 1, M_LSU);
                clr_lo = 1;
            end else if (!clr_n) begin
                clr_lo++;
            end else if (clr_n && !p_clr) begin
                chk(clr_lo >= M_RW, "R7 clear width", clr_lo, M_RW);
            end

            // R8 ready versus activity
            if (!ser_sel_n || !stage_n || !commit_n || !clr_n) begin
                chk(!cmd_ready, "R8 ready while busy", cmd_ready, 0);
                quiet = 0;
            end else begin
                quiet++;
            end
            if (cmd_ready && !p_rdy)
                chk(quiet - 1 >= M_REC, "R8 recovery", quiet - 1, M_REC);

            p_clk = ser_clk; p_sel = ser_sel_n; p_dat = ser_dat; p_stg = stage_n;
            p_cmt = commit_n; p_clr = clr_n; p_mid = clr_mid; p_rdy = cmd_ready;
        end
    end

    // driver: pushes the expected strobes, then offers the command
    task automatic send(input logic [1:0] kind, input logic [1:0] ch,
                        input logic [11:0] code, input logic cm, input logic md);
        cmd_kind   = kind;
        cmd_chan   = ch;
        cmd_code   = code;
        cmd_commit = cm;
        cmd_mid    = md;
        cmd_valid  = 1'b1;
        case (kind)
            2'd0: begin
                exp_q.push_back({EV_STG, ch, 2'b00, code});
                if (cm) exp_q.push_back({EV_CMT, 16'd0});
            end
            2'd1: exp_q.push_back({EV_CMT, 16'd0});
            2'd2: exp_q.push_back({EV_CLR, 15'd0, md});
            default: ;
        endcase
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int f0;
        int c0;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(ser_sel_n && ser_clk && stage_n && commit_n && clr_n, "R10 pins high in reset",
            {ser_sel_n, ser_clk, stage_n, commit_n, clr_n}, 5'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_sel_n && ser_clk && stage_n && commit_n && clr_n, "R10 pins high after reset",
            {ser_sel_n, ser_clk, stage_n, commit_n, clr_n}, 5'h1f);
        chk(clr_mid == 1'b0, "R10 level low", clr_mid, 0);
        chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);

        // R1/R5 write without commit
        c0 = n_commits;
        send(2'd0, 2'd0, 12'hABC, 1'b0, 1'b0);
        wait_idle();
        chk(n_commits == c0, "R5 no commit without flag", n_commits, c0);

        // R1/R5 write with commit
        send(2'd0, 2'd3, 12'h123, 1'b1, 1'b0);
        wait_idle();
        chk(n_commits == c0 + 1, "R5 commit after flagged write", n_commits, c0 + 1);

        // R6 update alone
        f0 = n_frames;
        send(2'd1, 2'd0, 12'h000, 1'b0, 1'b0);
        wait_idle();
        chk(n_frames == f0, "R6 update sends no frame", n_frames, f0);
        chk(n_commits == c0 + 2, "R6 update commits", n_commits, c0 + 2);

        // R7 clear to mid-scale, level held afterwards
        send(2'd2, 2'd0, 12'h000, 1'b0, 1'b1);
        wait_idle();
        chk(clr_mid == 1'b1, "R7 level held after clear", clr_mid, 1);
        send(2'd2, 2'd0, 12'h000, 1'b0, 1'b0);
        wait_idle();
        chk(clr_mid == 1'b0, "R7 zero-scale level held", clr_mid, 0);

        // R9 reserved kind
        f0 = n_frames;
        send(2'd3, 2'd2, 12'h555, 1'b1, 1'b1);
        chk(cmd_ready == 1'b1, "R9 ready stays high", cmd_ready, 1);
        repeat (40) @(negedge clk);
        chk(n_frames == f0, "R9 no frame", n_frames, f0);
        chk(clr_mid == 1'b0, "R9 level untouched", clr_mid, 0);
        chk(stage_n && commit_n && clr_n && ser_sel_n, "R9 pins resting",
            {stage_n, commit_n, clr_n, ser_sel_n}, 4'hf);

        // back-to-back traffic, accepted the cycle ready returns (R8)
        send(2'd0, 2'd1, 12'hFFF, 1'b0, 1'b0);
        send(2'd0, 2'd2, 12'h000, 1'b1, 1'b0);
        send(2'd1, 2'd0, 12'h000, 1'b0, 1'b0);
        send(2'd0, 2'd0, 12'h801, 1'b1, 1'b0);
        send(2'd2, 2'd0, 12'h000, 1'b0, 1'b1);
        send(2'd0, 2'd3, 12'h7FE, 1'b0, 1'b0);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R1/R5 all expected strobes seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule